// File: doc/BRIEF.md
# Dual-Master GPIO Port with Per-Pin Function Routing

This block is a 16-pin general-purpose I/O port that two bus masters can program at the same time. Each pin has a 4-bit function selector. Selector value 0 connects the pin to the port's own output data and direction registers. Selector values 1 to 15 hand the pin's output level and output enable to one of fifteen peripheral signal buses. A pin that belongs to a peripheral does not respond to anything written to the port's data registers.

The current pin levels can always be read through a two-flop synchronizer, whatever the selectors say. A set/clear register changes chosen output bits in a single write, so masters that own different bits never need a read-modify-write. A round-robin arbiter orders the accesses of the two masters. When both masters request in the same cycle, one is served and the other waits, and neither access is dropped. The pad itself, meaning the tri-state buffer, sits outside this block and is driven from `pin_o` and `pin_oe`.

Top module: `gpio_port_mux`

## Requirements
- R1: After reset the direction register, the output data register and both selector registers read as 0, and `pin_oe` is all zeros.
- R2: A pin whose selector is 0 drives `pin_o` from its output data bit (word address 1) and `pin_oe` from its direction bit (word address 0, where 1 means output).
- R3: A pin whose selector is k, with k from 1 to 15, drives `pin_o` from bit i of `alt_out[(k-1)*16 +: 16]` and `pin_oe` from the same bits of `alt_oe`. Writes to the output data register or the set/clear register leave such a pin's outputs unchanged.
- R4: The input data register (word address 2) returns `pin_i` through two flip-flops, for every pin and every selector. A read granted on the first or second rising edge after `pin_i` changes returns the old level. A read granted on the third edge returns the new level.
- R5: A write to the set/clear register (word address 3) sets the output data bits marked in write bits 15:0 and clears the bits marked in bits 31:16. Set wins when a bit is marked in both halves, and all other bits keep their value. A read of this address returns 0.
- R6: `m0_ready` and `m1_ready` are never high together. When both masters are valid, one is granted in that cycle and the other is granted on the next edge with its request intact.
- R7: When both masters request together, the grant goes to the master that was not granted in the most recent access. The first access after reset favours master 0.
- R8: A read granted on a rising edge raises that master's `rvalid` for exactly the following cycle, with the read data on `rdata`.
- R9: Selector registers sit at word addresses 4 (pins 0 to 7) and 5 (pins 8 to 15), with pin n at bits 4*(n mod 8)+3 down to 4*(n mod 8). They read back as written.
- R10: Writes to the input data register and to the unused word addresses 6 and 7 change no register, and reads of addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m0_valid | input | 1 | Master 0 request |
| m0_we | input | 1 | Master 0 write (1) or read (0) |
| m0_addr | input | 3 | Master 0 word address |
| m0_wdata | input | 32 | Master 0 write data |
| m0_ready | output | 1 | Master 0 grant in this cycle |
| m0_rdata | output | 32 | Master 0 read data |
| m0_rvalid | output | 1 | Master 0 read data valid |
| m1_valid | input | 1 | Master 1 request |
| m1_we | input | 1 | Master 1 write (1) or read (0) |
| m1_addr | input | 3 | Master 1 word address |
| m1_wdata | input | 32 | Master 1 write data |
| m1_ready | output | 1 | Master 1 grant in this cycle |
| m1_rdata | output | 32 | Master 1 read data |
| m1_rvalid | output | 1 | Master 1 read data valid |
| alt_out | input | 240 | Output levels of peripheral buses 1..15, 16 bits each |
| alt_oe | input | 240 | Output enables of peripheral buses 1..15, 16 bits each |
| pin_i | input | 16 | Pin levels from the pads |
| pin_o | output | 16 | Pin output levels to the pads |
| pin_oe | output | 16 | Pin output enables to the pads |

## Verification
The two functions that can meet in one cycle are the requests of the two masters. The bench raises both masters' valid on the same clock edge, with each master issuing a set/clear write on its own bit. From the grant cycles it judges that exactly one master won and that the winner alternates from round to round as R7 requires. It also judges that the loser followed on the next edge, and a read of the output data register afterwards must show both bits, which proves that neither update was lost. The sweeps check peripheral ownership by writing all ones and then all zeros to the data register while pins are routed to a peripheral, and the pin outputs must stay put.

// File: rtl/gpio_port_mux.sv
module gpio_port_mux #(
  parameter int NPIN = 16,
  parameter int SELW = 4,
  parameter int DW   = 32,
  parameter int AW   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         m0_valid,
  input  logic                         m0_we,
  input  logic [AW-1:0]                m0_addr,
  input  logic [DW-1:0]                m0_wdata,
  output logic                         m0_ready,
  output logic [DW-1:0]                m0_rdata,
  output logic                         m0_rvalid,
  input  logic                         m1_valid,
  input  logic                         m1_we,
  input  logic [AW-1:0]                m1_addr,
  input  logic [DW-1:0]                m1_wdata,
  output logic                         m1_ready,
  output logic [DW-1:0]                m1_rdata,
  output logic                         m1_rvalid,
  input  logic [(2**SELW-1)*NPIN-1:0]  alt_out,
  input  logic [(2**SELW-1)*NPIN-1:0]  alt_oe,
  input  logic [NPIN-1:0]              pin_i,
  output logic [NPIN-1:0]              pin_o,
  output logic [NPIN-1:0]              pin_oe
);
  localparam int NSRC  = 2**SELW;
  localparam int SELB  = NPIN*SELW;
  localparam int NSEL  = SELB/DW;
  localparam int A_DIR = 0;
  localparam int A_ODR = 1;
  localparam int A_IDR = 2;
  localparam int A_BSC = 3;
  localparam int A_SEL = 4;

  logic [NPIN-1:0] dir_q, odr_q, sync1_q, sync2_q;
  logic [SELB-1:0] sel_q;
  logic            pri_q;

  logic gnt0, gnt1, act, a_we;
  logic [AW-1:0] a_addr;
  logic [DW-1:0] a_wd, rd_mux;

  assign gnt1   = m1_valid & (~m0_valid | pri_q);
  assign gnt0   = m0_valid & ~gnt1;
  assign m0_ready = rst_n & gnt0;
  assign m1_ready = rst_n & gnt1;
  assign act    = m0_ready | m1_ready;
  assign a_we   = gnt1 ? m1_we   : m0_we;
  assign a_addr = gnt1 ? m1_addr : m0_addr;
  assign a_wd   = gnt1 ? m1_wdata : m0_wdata;

  always_comb begin
    rd_mux = '0;
    if (a_addr == AW'(A_DIR)) rd_mux[NPIN-1:0] = dir_q;
    if (a_addr == AW'(A_ODR)) rd_mux[NPIN-1:0] = odr_q;
    if (a_addr == AW'(A_IDR)) rd_mux[NPIN-1:0] = sync2_q;
    for (int r = 0; r < NSEL; r++)
      if (a_addr == AW'(A_SEL + r)) rd_mux = sel_q[r*DW +: DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      sel_q <= '0;
      pri_q <= 1'b0;
    end else if (act) begin
      pri_q <= gnt0;
      if (a_we) begin
        if (a_addr == AW'(A_DIR)) dir_q <= a_wd[NPIN-1:0];
        if (a_addr == AW'(A_ODR)) odr_q <= a_wd[NPIN-1:0];
        if (a_addr == AW'(A_BSC)) odr_q <= (odr_q & ~a_wd[2*NPIN-1:NPIN]) | a_wd[NPIN-1:0];
        for (int r = 0; r < NSEL; r++)
          if (a_addr == AW'(A_SEL + r)) sel_q[r*DW +: DW] <= a_wd;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m0_rvalid <= 1'b0;
      m1_rvalid <= 1'b0;
      m0_rdata  <= '0;
      m1_rdata  <= '0;
    end else begin
      m0_rvalid <= m0_ready & ~m0_we;
      m1_rvalid <= m1_ready & ~m1_we;
      if (m0_ready & ~m0_we) m0_rdata <= rd_mux;
      if (m1_ready & ~m1_we) m1_rdata <= rd_mux;
    end
  end

  logic [NPIN-1:0] src_o [NSRC];
  logic [NPIN-1:0] src_e [NSRC];

  assign src_o[0] = odr_q;
  assign src_e[0] = dir_q;

  for (genvar k = 1; k < NSRC; k++) begin : g_src
    assign src_o[k] = alt_out[(k-1)*NPIN +: NPIN];
    assign src_e[k] = alt_oe[(k-1)*NPIN +: NPIN];
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [SELW-1:0] fsel;
    logic [NPIN-1:0] vo, ve;
    assign fsel      = sel_q[i*SELW +: SELW];
    assign vo        = src_o[fsel];
    assign ve        = src_e[fsel];
    assign pin_o[i]  = vo[i];
    assign pin_oe[i] = ve[i];
  end
endmodule

// File: rtl/gpio_port_mux_chk.sv
module gpio_port_mux_chk (
  input logic clk,
  input logic rst_n,
  input logic m0_valid,
  input logic m0_we,
  input logic m0_ready,
  input logic m0_rvalid,
  input logic m1_valid,
  input logic m1_we,
  input logic m1_ready,
  input logic m1_rvalid
);
  assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(m0_ready && m1_ready));

  assert_grant_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_ready |-> m0_valid) and (m1_ready |-> m1_valid));

  assert_conflict_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_valid && m1_valid) |-> (m0_ready || m1_ready));

  assert_alternate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_valid && m1_valid && m0_ready) |=> ((m0_valid && m1_valid) |-> m1_ready));

  assert_alternate_back_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_valid && m1_valid && m1_ready) |=> ((m0_valid && m1_valid) |-> m0_ready));

  assert_rvalid0_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m0_valid && m0_ready && !m0_we) |=> m0_rvalid);

  assert_rvalid1_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m1_valid && m1_ready && !m1_we) |=> m1_rvalid);

  assert_no_spurious_rvalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(m0_ready && !m0_we)) |=> !m0_rvalid);
endmodule

bind gpio_port_mux gpio_port_mux_chk u_chk (
  .clk(clk), .rst_n(rst_n),
  .m0_valid(m0_valid), .m0_we(m0_we), .m0_ready(m0_ready), .m0_rvalid(m0_rvalid),
  .m1_valid(m1_valid), .m1_we(m1_we), .m1_ready(m1_ready), .m1_rvalid(m1_rvalid)
);

// File: tb/sim_gpio_port_mux.sv
module sim_gpio_port_mux;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m0_valid = 0, m0_we = 0, m1_valid = 0, m1_we = 0;
  logic [2:0] m0_addr = 0, m1_addr = 0;
  logic [31:0] m0_wdata = 0, m1_wdata = 0;
  logic m0_ready, m1_ready, m0_rvalid, m1_rvalid;
  logic [31:0] m0_rdata, m1_rdata;
  logic [239:0] alt_out, alt_oe;
  logic [15:0] pin_i = 16'h0;
  logic [15:0] pin_o, pin_oe;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int last_gnt = 1;
  int gcyc [2];
  bit finished = 0;

  int m_sel [16];
  logic [15:0] m_odr = 0, m_dir = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  gpio_port_mux u0 (
    .clk(clk), .rst_n(rst_n),
    .m0_valid(m0_valid), .m0_we(m0_we), .m0_addr(m0_addr), .m0_wdata(m0_wdata),
    .m0_ready(m0_ready), .m0_rdata(m0_rdata), .m0_rvalid(m0_rvalid),
    .m1_valid(m1_valid), .m1_we(m1_we), .m1_addr(m1_addr), .m1_wdata(m1_wdata),
    .m1_ready(m1_ready), .m1_rdata(m1_rdata), .m1_rvalid(m1_rvalid),
    .alt_out(alt_out), .alt_oe(alt_oe), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
  );

  function automatic logic [15:0] bus_o(int k);
    return 16'((k * 16'h3B5D) ^ 16'hC3A5 ^ (k << 11));
  endfunction
  function automatic logic [15:0] bus_e(int k);
    return 16'((k * 16'h2F17) ^ 16'h0FF0);
  endfunction

  function automatic logic [15:0] exp_o();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = bus_o(m_sel[i]);
      v[i] = (m_sel[i] == 0) ? m_odr[i] : b[i];
    end
    return v;
  endfunction
  function automatic logic [15:0] exp_e();
    logic [15:0] v;
    for (int i = 0; i < 16; i++) begin
      logic [15:0] b;
      b = bus_e(m_sel[i]);
      v[i] = (m_sel[i] == 0) ? m_dir[i] : b[i];
    end
    return v;
  endfunction
  function automatic logic [31:0] sel_word(int r);
    logic [31:0] w;
    for (int j = 0; j < 8; j++) w[4*j +: 4] = 4'(m_sel[8*r + j]);
    return w;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // Called at a falling edge; returns at the falling edge after the grant.
  task automatic acc(input int m, input bit we, input logic [2:0] a, input logic [31:0] d,
                     output logic [31:0] rd);
    bit got;
    got = 0;
    if (m == 0) begin m0_valid = 1; m0_we = we; m0_addr = a; m0_wdata = d; end
    else        begin m1_valid = 1; m1_we = we; m1_addr = a; m1_wdata = d; end
    while (!got) begin
      #1;
      if ((m == 0) ? m0_ready : m1_ready) begin
        got = 1; gcyc[m] = cyc; last_gnt = m;
      end
      @(negedge clk);
    end
    if (m == 0) begin m0_valid = 0; rd = m0_rdata; end
    else        begin m1_valid = 0; rd = m1_rdata; end
    if (!we) chk("R8", "rvalid after read grant", (m == 0) ? m0_rvalid : m1_rvalid, 1);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    logic [31:0] dummy;
    acc(0, 1, a, d, dummy);
  endtask
  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    acc(0, 0, a, 32'h0, v);
  endtask

  task automatic push_sel();
    logic [31:0] v;
    wr(3'd4, sel_word(0));
    wr(3'd5, sel_word(1));
    rd(3'd4, v); chk("R9", "selector low readback", v, sel_word(0));
    rd(3'd5, v); chk("R9", "selector high readback", v, sel_word(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int k = 1; k < 16; k++) begin
      alt_out[(k-1)*16 +: 16] = bus_o(k);
      alt_oe[(k-1)*16 +: 16]  = bus_e(k);
    end
    for (int i = 0; i < 16; i++) m_sel[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pin_oe in reset", pin_oe, 16'h0);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "pin_oe after reset", pin_oe, 16'h0);
    rd(3'd0, v); chk("R1", "direction reset", v, 0);
    rd(3'd1, v); chk("R1", "output data reset", v, 0);
    rd(3'd4, v); chk("R1", "selector low reset", v, 0);
    rd(3'd5, v); chk("R1", "selector high reset", v, 0);

    // R2 GPIO mode sweep
    for (int n = 0; n < 16; n++) begin
      m_dir = 16'((n * 16'h1F35) ^ (16'h1 << n));
      m_odr = 16'((n * 16'h6D2B) ^ 16'h9009);
      wr(3'd0, {16'h0, m_dir});
      wr(3'd1, {16'hFFFF, m_odr});
      chk("R2", "pin_o gpio", pin_o, m_odr);
      chk("R2", "pin_oe gpio", pin_oe, m_dir);
      rd(3'd1, v); chk("R2", "output data readback", v, {16'h0, m_odr});
    end

    // R3 uniform selector sweep
    for (int s = 0; s < 16; s++) begin
      for (int i = 0; i < 16; i++) m_sel[i] = s;
      push_sel();
      chk("R3", "pin_o uniform", pin_o, exp_o());
      chk("R3", "pin_oe uniform", pin_oe, exp_e());
      m_odr = 16'hFFFF; wr(3'd1, 32'hFFFF);
      chk("R3", "pin_o after odr ones", pin_o, exp_o());
      m_odr = 16'h0000; wr(3'd3, 32'hFFFF0000);
      chk("R3", "pin_o after clear all", pin_o, exp_o());
      chk("R3", "pin_oe after clear all", pin_oe, exp_e());
    end

    // R9 mixed per-pin selectors
    for (int rot = 0; rot < 16; rot++) begin
      for (int i = 0; i < 16; i++) m_sel[i] = (i + rot) % 16;
      push_sel();
      m_odr = 16'(16'hA55A ^ rot); wr(3'd1, {16'h0, m_odr});
      chk("R9", "pin_o mixed", pin_o, exp_o());
      chk("R9", "pin_oe mixed", pin_oe, exp_e());
    end

    // R5 set/clear
    for (int i = 0; i < 16; i++) m_sel[i] = 0;
    push_sel();
    m_dir = 16'hFFFF; wr(3'd0, 32'hFFFF);
    m_odr = 16'h0F0F; wr(3'd1, 32'h0F0F);
    for (int n = 0; n < 24; n++) begin
      logic [15:0] s, c;
      s = 16'((n * 16'h0913) ^ (16'h1 << (n % 16)));
      c = 16'((n * 16'h4C61) ^ 16'h3003);
      m_odr = (m_odr & ~c) | s;
      wr(3'd3, {c, s});
      rd(3'd1, v); chk("R5", "set/clear result", v, {16'h0, m_odr});
      chk("R5", "pin_o after set/clear", pin_o, m_odr);
    end
    m_odr = 16'h0000; wr(3'd1, 0);
    wr(3'd3, 32'h00FF00FF); m_odr = 16'h00FF;
    rd(3'd1, v); chk("R5", "set wins over clear", v, 32'h00FF);
    rd(3'd3, v); chk("R5", "set/clear reads zero", v, 0);

    // R4 input synchronizer latency, with pins both GPIO and peripheral-owned
    for (int n = 0; n < 16; n++) begin
      logic [15:0] oldv, newv;
      for (int i = 0; i < 16; i++) m_sel[i] = (n % 2 == 1) ? ((i + n) % 16) : 0;
      push_sel();
      repeat (3) @(negedge clk);
      oldv = pin_i;
      newv = 16'((n * 16'h5A3D) ^ 16'hBEEF ^ n);
      pin_i = newv;
      rd(3'd2, v); chk("R4", "input after 1 edge", v, {16'h0, oldv});
      rd(3'd2, v); chk("R4", "input after 2 edges", v, {16'h0, oldv});
      rd(3'd2, v); chk("R4", "input after 3 edges", v, {16'h0, newv});
    end

    // R10 ignored writes
    for (int i = 0; i < 16; i++) m_sel[i] = 15 - i;
    push_sel();
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd6, 32'hFFFFFFFF);
    wr(3'd7, 32'hFFFFFFFF);
    rd(3'd0, v); chk("R10", "direction kept", v, {16'h0, m_dir});
    rd(3'd1, v); chk("R10", "output data kept", v, {16'h0, m_odr});
    rd(3'd4, v); chk("R10", "selector low kept", v, sel_word(0));
    rd(3'd5, v); chk("R10", "selector high kept", v, sel_word(1));
    rd(3'd6, v); chk("R10", "addr 6 reads zero", v, 0);
    rd(3'd7, v); chk("R10", "addr 7 reads zero", v, 0);
    chk("R10", "pin_o kept", pin_o, exp_o());

    // R6 / R7 simultaneous requests
    for (int i = 0; i < 16; i++) m_sel[i] = 0;
    push_sel();
    m_odr = 16'h0; wr(3'd1, 0);
    for (int n = 0; n < 12; n++) begin
      int expw, w;
      logic [31:0] d0, d1;
      int b0, b1;
      b0 = n % 8; b1 = 8 + (n * 3) % 8;
      expw = (last_gnt == 0) ? 1 : 0;
      fork
        acc(0, 1, 3'd3, 32'h1 << b0, d0);
        acc(1, 1, 3'd3, 32'h1 << b1, d1);
      join
      w = (gcyc[0] < gcyc[1]) ? 0 : 1;
      chk("R7", "conflict winner", w, expw);
      chk("R6", "loser granted next edge", (w == 0) ? gcyc[1] - gcyc[0] : gcyc[0] - gcyc[1], 1);
      m_odr = m_odr | (16'h1 << b0) | (16'h1 << b1);
      rd(3'd1, v); chk("R6", "both updates kept", v, {16'h0, m_odr});
      m_odr = (n % 3 == 2) ? 16'h0 : m_odr;
      if (n % 3 == 2) wr(3'd3, 32'hFFFF0000);
    end

    // R6 read against write in the same cycle
    begin
      logic [31:0] d0, d1;
      fork
        acc(0, 1, 3'd0, 32'h00005A5A, d0);
        acc(1, 0, 3'd1, 32'h0, d1);
      join
      m_dir = 16'h5A5A;
      chk("R6", "master 1 read of output data", d1, {16'h0, m_odr});
      rd(3'd0, v); chk("R6", "master 0 direction write", v, 32'h5A5A);
      chk("R2", "pin_oe after contended write", pin_oe, m_dir);
    end

    finished = 1;
    report();
    $finish;
  end
endmodule